// File: doc/BRIEF.md
# Data Segment Map Translator

This block turns a logical data address into a physical address. The logical data space is cut into equal blocks, and each block has its own 16-bit map register. The map register picks a target space and a segment. The target space is unified memory, instruction memory or on-chip data. A map register can also switch its block into I/O mode, where one nibble of the register chooses a 64 KB I/O page. Along with the address, the block reports how many bytes of the requested access fit before the next block boundary. It raises a fault for addresses past the mapped window and for the reserved space code.

The map registers sit in a small register window on a bus port, with one write port and one registered read port. A translation request is sampled on a clock edge. The physical address, the space tag, the granted length and the fault flag are registered and appear one cycle later with a valid strobe. The memories behind the translated address are outside this block.

Top module: `dsm_translator`

## Requirements
- R1: A request presented with `req_valid` high on a rising edge produces its result on the outputs after that edge, with `xl_valid` high for exactly that cycle. Back-to-back requests give back-to-back results, and `xl_valid` is low in every cycle that follows an edge without a request. Reset clears `xl_valid`.
- R2: The map register index is logical address bits 15:14 and the in-block offset is bits 13:0. The block size is 16384 bytes.
- R3: A logical address at or above 0x10000 (the block size times four) is a fault. A fault gives `xl_fault`=1, `xl_len`=0, `xl_paddr`=0 and `xl_space`=0.
- R4: For a non-faulting request, `xl_len` is the smaller of `req_len` and 16384 minus the offset, so an access never crosses a block boundary.
- R5: With map bit 15 clear, map bits 13:12 select the space and bits 9:0 hold the segment. Code 00 is unified memory (tag 0) and code 01 is instruction memory (tag 1). For both, the physical address is segment×16384 + offset.
- R6: Space code 10 is on-chip data (tag 2), with physical address (segment<<16) + index×16384 + offset.
- R7: Space code 11 with map bit 15 clear is reserved and faults as in R3.
- R8: With map bit 15 set, the block is in I/O mode (tag 3). Let k be offset bits 13:12. Map nibble (3−k) gives a page, where nibble n is map bits 4n+3:4n. The physical address is page×0x10000 + 0xC000 + offset.
- R9: Map register i is written and read at window address 0xFF08+2i. Address 0xFF04 aliases register 2 for both writes and reads. A write to any other address changes nothing, and a read of any other address returns 0. A read returns its data one cycle after the address is sampled.
- R10: After reset the map registers hold 0x2000, 0x2000, 0x2000 and 0x0000 for indices 0 to 3.
- R11: A request sampled on the same edge as a map write is translated with the map value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 18 | Logical data address |
| req_len | input | 16 | Requested access length in bytes |
| win_we | input | 1 | Map window write enable |
| win_waddr | input | 16 | Map window write address |
| win_wdata | input | 16 | Map window write data |
| win_raddr | input | 16 | Map window read address |
| win_rdata | output | 16 | Map window read data, registered |
| xl_valid | output | 1 | Result valid strobe |
| xl_paddr | output | 26 | Physical address within the target space |
| xl_space | output | 2 | Space tag: 0 unified, 1 instruction, 2 on-chip data, 3 I/O |
| xl_len | output | 16 | Granted length in bytes |
| xl_fault | output | 1 | Translation fault |

## Verification
The translation is first driven with the reset map. It is then driven with each space code written into different registers, which separates the unified and instruction formulas from the data formula: only the data formula adds the register index. In I/O mode, one address per nibble position shows whether the nibble order is reversed. Lengths are chosen below, at and above the room left in a block, and at the last byte of a block, so the clip boundary is pinned down. Out-of-range addresses, reserved codes, stray and odd window addresses, the alias, and a map write in the same cycle as a request cover the remaining paths.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    SP_UNIF = 2'd0,
    SP_INSN = 2'd1,
    SP_DATA = 2'd2,
    SP_IO   = 2'd3
  } space_e;

  // Power-on content of map register idx (R10): every entry but the last
  // points at on-chip data segment 0, the last at unified segment 0.
  function automatic logic [15:0] map_reset_val(input int idx, input int num_maps);
    return (idx == num_maps - 1) ? 16'h0000 : 16'h2000;
  endfunction

endpackage

// File: rtl/dsm_map_window.sv
module dsm_map_window
  import dsm_pkg::*;
#(
  parameter int NUM_MAPS   = 4,
  parameter int MAP_W      = 16,
  parameter int WA_W       = 16,
  parameter int WIN_BASE   = 'hFF08,
  parameter int ALIAS_ADDR = 'hFF04,
  parameter int ALIAS_IDX  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [WA_W-1:0]                 waddr,
  input  logic [MAP_W-1:0]                wdata,
  input  logic [WA_W-1:0]                 raddr,
  output logic [MAP_W-1:0]                rdata,
  output logic [NUM_MAPS-1:0][MAP_W-1:0]  maps
);

  localparam logic [WA_W-1:0] ALIAS_A = WA_W'(ALIAS_ADDR);

  logic [NUM_MAPS-1:0] rd_hit;
  logic [MAP_W-1:0]    rd_next;

  // One storage word per map register, each decoding its own address (R9)
  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    localparam logic [WA_W-1:0] MY_A = WA_W'(WIN_BASE + 2 * g);
    localparam bit HAS_ALIAS = (g == ALIAS_IDX);
    logic wr_hit;

    assign wr_hit    = we && ((waddr == MY_A) || (HAS_ALIAS && (waddr == ALIAS_A)));
    assign rd_hit[g] = (raddr == MY_A) || (HAS_ALIAS && (raddr == ALIAS_A));

    always_ff @(posedge clk) begin
      if (rst)         maps[g] <= MAP_W'(map_reset_val(g, NUM_MAPS));  // R10
      else if (wr_hit) maps[g] <= wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_MAPS; i++)
      if (rd_hit[i]) rd_next = maps[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/dsm_xlate_core.sv
module dsm_xlate_core
  import dsm_pkg::*;
#(
  parameter int LA_W       = 18,
  parameter int BLK_W      = 14,
  parameter int NUM_MAPS   = 4,
  parameter int MAP_W      = 16,
  parameter int SEG_W      = 10,
  parameter int PA_W       = 26,
  parameter int IO_BIT     = 15,
  parameter int SPACE_LSB  = 12,
  parameter int NIB_LSB    = 12,
  parameter int PAGE_SHIFT = 16,
  parameter int IO_BASE    = 'hC000
) (
  input  logic [LA_W-1:0]                 laddr,
  input  logic [NUM_MAPS-1:0][MAP_W-1:0]  maps,
  output logic [PA_W-1:0]                 paddr,
  output space_e                          space,
  output logic                            fault,
  output logic [BLK_W-1:0]                offset
);

  localparam int IDX_W = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1;
  localparam logic [LA_W:0] LIMIT = (LA_W+1)'(NUM_MAPS) << BLK_W;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [MAP_W-1:0] map_sel;
  logic [SEG_W-1:0] seg;
  logic [1:0]       sp_code;
  logic             is_io;
  logic [1:0]       nib_k;
  logic [1:0]       nib_pos;
  logic [3:0]       page;
  logic [PA_W-1:0]  pa_blk;
  logic [PA_W-1:0]  pa_data;
  logic [PA_W-1:0]  pa_io;

  // R2: index above the offset bits
  assign idx      = laddr[BLK_W +: IDX_W];
  assign offset   = laddr[BLK_W-1:0];
  assign in_range = {1'b0, laddr} < LIMIT;                 // R3
  assign map_sel  = maps[idx];

  assign seg     = map_sel[SEG_W-1:0];
  assign sp_code = map_sel[SPACE_LSB +: 2];
  assign is_io   = map_sel[IO_BIT];

  // R8: quarter of the block picks a nibble, highest nibble first
  assign nib_k   = offset[NIB_LSB +: 2];
  assign nib_pos = 2'd3 - nib_k;
  assign page    = map_sel[{nib_pos, 2'b00} +: 4];

  assign pa_blk  = (PA_W'(seg) << BLK_W) | PA_W'(offset);
  assign pa_data = (PA_W'(seg) << PAGE_SHIFT) + (PA_W'(idx) << BLK_W) + PA_W'(offset);
  assign pa_io   = (PA_W'(page) << PAGE_SHIFT) + PA_W'(IO_BASE) + PA_W'(offset);

  always_comb begin
    paddr = '0;
    space = SP_UNIF;
    fault = 1'b0;
    if (!in_range) begin
      fault = 1'b1;
    end else if (is_io) begin
      paddr = pa_io;
      space = SP_IO;
    end else begin
      unique case (sp_code)
        2'b00: begin paddr = pa_blk;  space = SP_UNIF; end  // R5
        2'b01: begin paddr = pa_blk;  space = SP_INSN; end  // R5
        2'b10: begin paddr = pa_data; space = SP_DATA; end  // R6
        default: fault = 1'b1;                              // R7
      endcase
    end
  end

endmodule

// File: rtl/dsm_len_clip.sv
module dsm_len_clip #(
  parameter int BLK_W = 14,
  parameter int LEN_W = 16
) (
  input  logic [BLK_W-1:0] offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             fault,
  output logic [LEN_W-1:0] grant_len
);

  localparam int CW = (LEN_W > BLK_W + 1) ? LEN_W : BLK_W + 1;

  logic [CW-1:0] room;
  logic [CW-1:0] want;

  // R4: bytes left before the next block boundary
  assign room = (CW'(1) << BLK_W) - CW'(offset);
  assign want = CW'(req_len);

  always_comb begin
    if (fault)            grant_len = '0;
    else if (want < room) grant_len = LEN_W'(want);
    else                  grant_len = LEN_W'(room);
  end

endmodule

// File: rtl/dsm_translator.sv
module dsm_translator
  import dsm_pkg::*;
#(
  parameter int LA_W       = 18,
  parameter int BLK_W      = 14,
  parameter int NUM_MAPS   = 4,
  parameter int MAP_W      = 16,
  parameter int SEG_W      = 10,
  parameter int PA_W       = 26,
  parameter int LEN_W      = 16,
  parameter int WA_W       = 16,
  parameter int WIN_BASE   = 'hFF08,
  parameter int ALIAS_ADDR = 'hFF04,
  parameter int ALIAS_IDX  = 2,
  parameter int IO_BASE    = 'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              win_we,
  input  logic [WA_W-1:0]   win_waddr,
  input  logic [MAP_W-1:0]  win_wdata,
  input  logic [WA_W-1:0]   win_raddr,
  output logic [MAP_W-1:0]  win_rdata,
  output logic              xl_valid,
  output logic [PA_W-1:0]   xl_paddr,
  output logic [1:0]        xl_space,
  output logic [LEN_W-1:0]  xl_len,
  output logic              xl_fault
);

  logic [NUM_MAPS-1:0][MAP_W-1:0] maps;
  logic [PA_W-1:0]   c_paddr;
  space_e            c_space;
  logic              c_fault;
  logic [BLK_W-1:0]  c_offset;
  logic [LEN_W-1:0]  c_len;

  dsm_map_window #(
    .NUM_MAPS(NUM_MAPS), .MAP_W(MAP_W), .WA_W(WA_W),
    .WIN_BASE(WIN_BASE), .ALIAS_ADDR(ALIAS_ADDR), .ALIAS_IDX(ALIAS_IDX)
  ) u_win (
    .clk(clk), .rst(rst), .we(win_we), .waddr(win_waddr), .wdata(win_wdata),
    .raddr(win_raddr), .rdata(win_rdata), .maps(maps)
  );

  dsm_xlate_core #(
    .LA_W(LA_W), .BLK_W(BLK_W), .NUM_MAPS(NUM_MAPS), .MAP_W(MAP_W),
    .SEG_W(SEG_W), .PA_W(PA_W), .IO_BASE(IO_BASE)
  ) u_core (
    .laddr(req_laddr), .maps(maps), .paddr(c_paddr), .space(c_space),
    .fault(c_fault), .offset(c_offset)
  );

  dsm_len_clip #(.BLK_W(BLK_W), .LEN_W(LEN_W)) u_clip (
    .offset(c_offset), .req_len(req_len), .fault(c_fault), .grant_len(c_len)
  );

  // R1, R11: outputs registered; the map seen here is the pre-write value
  always_ff @(posedge clk) begin
    if (rst) begin
      xl_valid <= 1'b0;
      xl_paddr <= '0;
      xl_space <= '0;
      xl_len   <= '0;
      xl_fault <= 1'b0;
    end else begin
      xl_valid <= req_valid;
      if (req_valid) begin
        xl_paddr <= c_paddr;
        xl_space <= c_space;
        xl_len   <= c_len;
        xl_fault <= c_fault;
      end
    end
  end

endmodule

// File: rtl/dsm_translator_chk.sv
module dsm_translator_chk #(
  parameter int LA_W     = 18,
  parameter int BLK_W    = 14,
  parameter int NUM_MAPS = 4,
  parameter int PA_W     = 26,
  parameter int LEN_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [LA_W-1:0]   req_laddr,
  input logic [LEN_W-1:0]  req_len,
  input logic              xl_valid,
  input logic [PA_W-1:0]   xl_paddr,
  input logic [1:0]        xl_space,
  input logic [LEN_W-1:0]  xl_len,
  input logic              xl_fault
);

  localparam logic [LA_W:0] LIMIT = (LA_W+1)'(NUM_MAPS) << BLK_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> xl_valid);  // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !xl_valid);  // R1

  AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_laddr} >= LIMIT)) |=> xl_fault);  // R3

  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_fault) |-> (xl_len == '0 && xl_paddr == '0 && xl_space == 2'd0));  // R3

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (xl_len <= $past(req_len)));  // R4

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (xl_fault ||
      ((32'($past(req_laddr[BLK_W-1:0])) + 32'(xl_len)) <= (32'd1 << BLK_W))));  // R4

  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && !xl_fault && xl_space == 2'd3) |-> (xl_paddr[15:14] == 2'b11));  // R8

endmodule

bind dsm_translator dsm_translator_chk #(
  .LA_W(LA_W), .BLK_W(BLK_W), .NUM_MAPS(NUM_MAPS), .PA_W(PA_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
  .req_len(req_len), .xl_valid(xl_valid), .xl_paddr(xl_paddr),
  .xl_space(xl_space), .xl_len(xl_len), .xl_fault(xl_fault)
);

// File: tb/test_dsm_translator.sv
`timescale 1ns/1ps
module test_dsm_translator;

  typedef struct packed {
    logic        fault;
    logic [1:0]  sp;
    logic [25:0] pa;
    logic [15:0] len;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [17:0] req_laddr = '0;
  logic [15:0] req_len = '0;
  logic        win_we = 1'b0;
  logic [15:0] win_waddr = '0;
  logic [15:0] win_wdata = '0;
  logic [15:0] win_raddr = '0;
  logic [15:0] win_rdata;
  logic        xl_valid;
  logic [25:0] xl_paddr;
  logic [1:0]  xl_space;
  logic [15:0] xl_len;
  logic        xl_fault;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] sh [4];
  exp_t  q_exp [$];
  string q_tag [$];

  always #2.5 clk = ~clk;

  dsm_translator i_dsm_translator (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_len(req_len), .win_we(win_we), .win_waddr(win_waddr),
    .win_wdata(win_wdata), .win_raddr(win_raddr), .win_rdata(win_rdata),
    .xl_valid(xl_valid), .xl_paddr(xl_paddr), .xl_space(xl_space),
    .xl_len(xl_len), .xl_fault(xl_fault)
  );

  function automatic exp_t model(input logic [17:0] a, input logic [15:0] l);
    exp_t e;
    logic [1:0]  ix;
    logic [13:0] off;
    logic [15:0] m;
    logic [3:0]  pg;
    int room;
    e = '0;
    ix = a[15:14];
    off = a[13:0];
    m = sh[ix];
    if (a >= 18'h10000) e.fault = 1'b1;
    else if (m[15]) begin
      pg = m[4*(3-int'(off[13:12])) +: 4];
      e.sp = 2'd3;
      e.pa = 26'(pg) * 26'h10000 + 26'hC000 + 26'(off);
    end else begin
      case (m[13:12])
        2'b00: begin e.sp = 2'd0; e.pa = 26'(m[9:0]) * 26'h4000 + 26'(off); end
        2'b01: begin e.sp = 2'd1; e.pa = 26'(m[9:0]) * 26'h4000 + 26'(off); end
        2'b10: begin e.sp = 2'd2; e.pa = (26'(m[9:0]) << 16) + 26'(ix) * 26'h4000 + 26'(off); end
        default: e.fault = 1'b1;
      endcase
    end
    room = 16384 - int'(off);
    if (!e.fault) e.len = (int'(l) < room) ? l : 16'(room);
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv, input string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic void shadow_wr(input logic [15:0] a, input logic [15:0] d);
    for (int i = 0; i < 4; i++)
      if (a == 16'hFF08 + 16'(2*i)) sh[i] = d;
    if (a == 16'hFF04) sh[2] = d;
  endfunction

  task automatic win_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    win_we = 1'b1; win_waddr = a; win_wdata = d;
    @(negedge clk);
    win_we = 1'b0;
    shadow_wr(a, d);
  endtask

  task automatic win_read(input logic [15:0] a, input logic [15:0] expv, input string tag);
    @(negedge clk);
    win_raddr = a;
    @(negedge clk);
    check(tag, 64'(win_rdata), 64'(expv), $sformatf("read 0x%0h", a));
  endtask

  // Driver: one-cycle request, expected item pushed for the monitor
  task automatic xlate(input logic [17:0] a, input logic [15:0] l, input string tag);
    @(negedge clk);
    q_exp.push_back(model(a, l));
    q_tag.push_back(tag);
    req_valid = 1'b1; req_laddr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare each result against the head of the queue
  always @(negedge clk) begin
    if (!rst && xl_valid) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1 unexpected result: actual valid 1 expected 0");
      end else begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, 64'(xl_fault), 64'(e.fault), "fault");
        check(t, 64'(xl_space), 64'(e.sp), "space");
        check(t, 64'(xl_paddr), 64'(e.pa), "paddr");
        check(t, 64'(xl_len), 64'(e.len), "len");
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    sh[0] = 16'h2000; sh[1] = 16'h2000; sh[2] = 16'h2000; sh[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 64'(xl_valid), 64'd0, "valid after reset");
    // R10 reset contents, R9 alias read
    win_read(16'hFF08, 16'h2000, "R10");
    win_read(16'hFF0A, 16'h2000, "R10");
    win_read(16'hFF0C, 16'h2000, "R10");
    win_read(16'hFF0E, 16'h0000, "R10");
    win_read(16'hFF04, 16'h2000, "R9");
    // Reset map: data segment 0 and unified segment 0
    xlate(18'h01234, 16'd4, "R6");
    xlate(18'h0C010, 16'd8, "R2");
    // Unified and instruction segments
    win_write(16'hFF08, 16'h0005);
    xlate(18'h00100, 16'd2, "R5");
    win_write(16'hFF0A, 16'h1003);
    xlate(18'h04020, 16'd16, "R5");
    // Alias write, data space adds index
    win_write(16'hFF04, 16'h2007);
    win_read(16'hFF0C, 16'h2007, "R9");
    xlate(18'h08004, 16'd4, "R6");
    // Reserved code
    win_write(16'hFF0E, 16'h3001);
    xlate(18'h0C000, 16'd4, "R7");
    // I/O mode: one address per nibble
    win_write(16'hFF0E, 16'h8ABC);
    xlate(18'h0C000, 16'd2, "R8");
    xlate(18'h0D234, 16'd2, "R8");
    xlate(18'h0E008, 16'd2, "R8");
    xlate(18'h0FFFF, 16'd8, "R8");
    // Length clipping
    xlate(18'h03FF0, 16'h0040, "R4");
    xlate(18'h03FF0, 16'h0010, "R4");
    xlate(18'h00000, 16'hFFFF, "R4");
    xlate(18'h00200, 16'h0000, "R4");
    // Out of range
    xlate(18'h10000, 16'd4, "R3");
    xlate(18'h3FFFF, 16'd4, "R3");
    // Writes outside the window are ignored
    win_write(16'hFF06, 16'hFFFF);
    win_write(16'hFF09, 16'hFFFF);
    win_write(16'h0008, 16'hFFFF);
    win_read(16'hFF08, 16'h0005, "R9");
    win_read(16'hFF0A, 16'h1003, "R9");
    win_read(16'hFF0C, 16'h2007, "R9");
    win_read(16'hFF0E, 16'h8ABC, "R9");
    win_read(16'hFF06, 16'h0000, "R9");
    xlate(18'h00100, 16'd2, "R9");
    // Same-edge write and request use the old map value
    @(negedge clk);
    q_exp.push_back(model(18'h00010, 16'd4));
    q_tag.push_back("R11");
    req_valid = 1'b1; req_laddr = 18'h00010; req_len = 16'd4;
    win_we = 1'b1; win_waddr = 16'hFF08; win_wdata = 16'h2001;
    @(negedge clk);
    req_valid = 1'b0; win_we = 1'b0;
    shadow_wr(16'hFF08, 16'h2001);
    xlate(18'h00010, 16'd4, "R11");
    // Back-to-back requests
    @(negedge clk);
    q_exp.push_back(model(18'h04000, 16'd3)); q_tag.push_back("R1");
    req_valid = 1'b1; req_laddr = 18'h04000; req_len = 16'd3;
    @(negedge clk);
    q_exp.push_back(model(18'h0EFFF, 16'd9)); q_tag.push_back("R1");
    req_laddr = 18'h0EFFF; req_len = 16'd9;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", 64'(xl_valid), 64'd0, "valid when idle");
    repeat (2) @(negedge clk);
    check("R1", 64'(q_exp.size()), 64'd0, "results outstanding");
    finish_run();
  end

endmodule